// File: doc/BRIEF.md
# Status-Flag ALU

This block is a small integer datapath with an attached flag register. In one pass it combines two operands with an add, a subtract, a bitwise logic function, or a one-position shift or rotate of the first operand. The operands are either full 16-bit words or the low 8-bit halves. The result leaves the block combinationally in the same cycle. From that result the block derives six status indications: carry, parity, auxiliary carry, zero, sign and overflow.

The status indications are loaded into a 16-bit flag word on the clock edge where the update strobe is high. The same word holds three control bits: trap, interrupt enable and direction. Only an explicit control write changes them, and the block does not act on them. A decoder upstream chooses the operation and width, and it decides whether a given step should leave a record in the flags.

Reset is asynchronous and active low. Its release is synchronised inside the block, so the flag word stays cleared for two clock edges after the reset pin rises.

Top module: `flag_alu`

## Requirements
- R1: While reset is asserted, and for two rising clock edges after it is released, the flag word reads 0x0000.
- R2: Opcode 0 (add) gives A+B and opcode 1 (subtract) gives A-B, both modulo the active width. On update, carry is set by a carry out of the top active bit for add, and by a borrow for subtract (A < B unsigned).
- R3: For add and subtract, overflow is set exactly when the signed result cannot be represented in the active width.
- R4: For add and subtract, the auxiliary flag is the carry or borrow between bit 3 and bit 4. Logic, shift and rotate operations clear it.
- R5: Sign equals the top active bit of the result, and zero is set when the active result is all zeros.
- R6: Parity is set when the low 8 bits of the result contain an even number of ones.
- R7: Opcodes 2, 3 and 4 give A AND B, A OR B and A XOR B, and they clear carry and overflow.
- R8: Each shift or rotate acts on A by one position: opcode 5 shifts left, 6 shifts right logically, 7 shifts right arithmetically, 8 rotates left and 9 rotates right. Carry receives the bit moved out, and overflow is set when the top active bit of the result differs from that of A.
- R9: With byte_mode high, only the low 8 bits of each operand are used, result bits 15:8 are zero, and carry, overflow, sign and zero are taken at bit 7.
- R10: Flag word layout: carry bit 0, parity 2, auxiliary 4, zero 6, sign 7, trap 8, interrupt enable 9, direction 10, overflow 11. All other bits read 0.
- R11: Status flags change only on a rising edge where flag_upd is high, and they show the new values after that edge.
- R12: A rising edge with ctl_we high loads ctl_din bit 0 into trap, bit 1 into interrupt enable and bit 2 into direction. Arithmetic never alters these three bits.
- R13: Opcodes 10 to 15 pass A (masked to the active width) to the result and leave the flag word unchanged even when flag_upd is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 4 | Operation code |
| byte_mode | input | 1 | 1 selects 8-bit operation |
| opa | input | 16 | Operand A |
| opb | input | 16 | Operand B |
| flag_upd | input | 1 | Load status flags on this edge |
| ctl_we | input | 1 | Load control flags on this edge |
| ctl_din | input | 3 | Control flag values: direction, interrupt enable, trap |
| result | output | 16 | Combinational result |
| flags | output | 16 | Registered flag word |

## Verification
A wrong carry, borrow or half-carry term inside the datapath appears on the flag word exactly one edge after the strobe that loads it, so every vector is checked per flag on the cycle after its update. A wrong width decision shows at once on the combinational result, because bits 15:8 must be zero in byte mode. Corruption of the stored state, such as control bits taking arithmetic values or status changing without a strobe, shows on the first edge after the offending stimulus. Those bits are compared on every cycle and not only after updates.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  localparam int FLAG_W  = 16;
  localparam int CF_POS  = 0;
  localparam int PF_POS  = 2;
  localparam int AF_POS  = 4;
  localparam int ZF_POS  = 6;
  localparam int SF_POS  = 7;
  localparam int TF_POS  = 8;
  localparam int IE_POS  = 9;
  localparam int DF_POS  = 10;
  localparam int OF_POS  = 11;
  localparam int PAR_W   = 8;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_SHL = 4'd5,
    OP_SHR = 4'd6,
    OP_SAR = 4'd7,
    OP_ROL = 4'd8,
    OP_ROR = 4'd9
  } op_t;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } status_t;

  typedef struct packed {
    logic dir;
    logic ien;
    logic trp;
  } ctl_t;

endpackage

// File: rtl/flag_alu_rst_sync.sv
module flag_alu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/flag_alu_core.sv
module flag_alu_core
  import flag_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  op_t          op_i,
  input  logic         byte_i,
  output logic [W-1:0] res_o,
  output logic         cry_o,
  output logic         ovf_o,
  output logic         aux_o,
  output logic         known_o
);
  localparam int HW = W / 2;

  logic [W-1:0] lane_mask, top_bit, a_m, b_m, raw;
  logic [W:0]   sum_x, dif_x;
  logic         msb_a, msb_b, msb_r, add_co, sub_bo;

  always_comb begin
    lane_mask = byte_i ? {{(W-HW){1'b0}}, {HW{1'b1}}} : {W{1'b1}};
    top_bit   = byte_i ? (W'(1) << (HW - 1)) : (W'(1) << (W - 1));
    a_m       = a_i & lane_mask;
    b_m       = b_i & lane_mask;
    msb_a     = |(a_m & top_bit);
    msb_b     = |(b_m & top_bit);
    sum_x     = {1'b0, a_m} + {1'b0, b_m};
    dif_x     = {1'b0, a_m} - {1'b0, b_m};
    add_co    = byte_i ? sum_x[HW] : sum_x[W];
    sub_bo    = byte_i ? dif_x[HW] : dif_x[W];

    raw     = a_m;
    cry_o   = 1'b0;
    aux_o   = 1'b0;
    known_o = 1'b1;
    case (op_i)
      OP_ADD: begin raw = sum_x[W-1:0]; cry_o = add_co; end
      OP_SUB: begin raw = dif_x[W-1:0]; cry_o = sub_bo; end
      OP_AND: raw = a_m & b_m;
      OP_OR:  raw = a_m | b_m;
      OP_XOR: raw = a_m ^ b_m;
      OP_SHL: begin raw = a_m << 1;                       cry_o = msb_a;  end
      OP_SHR: begin raw = a_m >> 1;                       cry_o = a_m[0]; end
      OP_SAR: begin raw = (a_m >> 1) | (msb_a ? top_bit : '0);   cry_o = a_m[0]; end
      OP_ROL: begin raw = (a_m << 1) | W'(msb_a);        cry_o = msb_a;  end
      OP_ROR: begin raw = (a_m >> 1) | (a_m[0] ? top_bit : '0);  cry_o = a_m[0]; end
      default: known_o = 1'b0;
    endcase

    res_o = raw & lane_mask;
    msb_r = |(res_o & top_bit);

    if (op_i == OP_ADD || op_i == OP_SUB)
      aux_o = a_m[4] ^ b_m[4] ^ raw[4];

    case (op_i)
      OP_ADD: ovf_o = (msb_a == msb_b) && (msb_r != msb_a);
      OP_SUB: ovf_o = (msb_a != msb_b) && (msb_r != msb_a);
      OP_SHL, OP_SHR, OP_SAR, OP_ROL, OP_ROR: ovf_o = msb_r ^ msb_a;
      default: ovf_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/flag_alu_stat.sv
module flag_alu_stat
  import flag_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] res_i,
  input  logic         byte_i,
  input  logic         cry_i,
  input  logic         ovf_i,
  input  logic         aux_i,
  output status_t      st_o
);
  localparam int HW = W / 2;

  always_comb begin
    st_o.cry = cry_i;
    st_o.ovf = ovf_i;
    st_o.aux = aux_i;
    st_o.par = ~(^res_i[PAR_W-1:0]);
    st_o.sgn = byte_i ? res_i[HW-1] : res_i[W-1];
    st_o.zro = byte_i ? (res_i[HW-1:0] == '0) : (res_i == '0);
  end
endmodule

// File: rtl/flag_alu_freg.sv
module flag_alu_freg
  import flag_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_en,
  input  status_t           st_d,
  input  logic              ctl_en,
  input  ctl_t              ctl_d,
  output logic [FLAG_W-1:0] flags_o
);
  status_t st_q, st_nxt;
  ctl_t    ctl_q, ctl_nxt;

  always_comb begin
    st_nxt  = st_en  ? st_d  : st_q;
    ctl_nxt = ctl_en ? ctl_d : ctl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      ctl_q <= '0;
    end else begin
      st_q  <= st_nxt;
      ctl_q <= ctl_nxt;
    end
  end

  always_comb begin
    flags_o         = '0;
    flags_o[CF_POS] = st_q.cry;
    flags_o[PF_POS] = st_q.par;
    flags_o[AF_POS] = st_q.aux;
    flags_o[ZF_POS] = st_q.zro;
    flags_o[SF_POS] = st_q.sgn;
    flags_o[OF_POS] = st_q.ovf;
    flags_o[TF_POS] = ctl_q.trp;
    flags_o[IE_POS] = ctl_q.ien;
    flags_o[DF_POS] = ctl_q.dir;
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    op,
  input  logic          byte_mode,
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  input  logic          flag_upd,
  input  logic          ctl_we,
  input  logic [2:0]    ctl_din,
  output logic [W-1:0]  result,
  output logic [15:0]   flags
);
  logic    rst_q_n, cry, ovf, aux, known;
  status_t st;
  ctl_t    ctl_w;

  flag_alu_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  flag_alu_core #(.W(W)) u_core (
    .a_i(opa), .b_i(opb), .op_i(op_t'(op)), .byte_i(byte_mode),
    .res_o(result), .cry_o(cry), .ovf_o(ovf), .aux_o(aux), .known_o(known)
  );

  flag_alu_stat #(.W(W)) u_stat (
    .res_i(result), .byte_i(byte_mode), .cry_i(cry), .ovf_i(ovf),
    .aux_i(aux), .st_o(st)
  );

  assign ctl_w = ctl_t'(ctl_din[2:0]);

  flag_alu_freg u_freg (
    .clk(clk), .rst_n(rst_q_n),
    .st_en(flag_upd & known), .st_d(st),
    .ctl_en(ctl_we), .ctl_d(ctl_w),
    .flags_o(flags)
  );
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  op,
  input logic        byte_mode,
  input logic        flag_upd,
  input logic        ctl_we,
  input logic [2:0]  ctl_din,
  input logic [15:0] result,
  input logic [15:0] flags
);
  localparam logic [15:0] STAT_M = 16'h08D5;
  localparam logic [15:0] CTL_M  = 16'h0700;

  p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & ~(STAT_M | CTL_M)) == 16'h0);

  p_byte_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_mode |-> result[15:8] == 8'h00);

  p_status_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_upd |=> $stable(flags & STAT_M));

  p_ctl_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> flags[10:8] == $past(ctl_din));

  p_ctl_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(flags[10:8]));

  p_logic_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_upd && op >= 4'd2 && op <= 4'd4) |=> (!flags[0] && !flags[11] && !flags[4]));

  p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_upd && op <= 4'd9) |=> flags[6] == ($past(result) == 16'h0));

  p_reserved_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_upd && !ctl_we && op >= 4'd10) |=> $stable(flags));
endmodule

bind flag_alu flag_alu_chk u_chk (
  .clk(clk), .rst_n(rst_q_n), .op(op), .byte_mode(byte_mode),
  .flag_upd(flag_upd), .ctl_we(ctl_we), .ctl_din(ctl_din),
  .result(result), .flags(flags)
);

// File: tb/flag_alu_test.sv
module flag_alu_test;
  logic        clk, rst_n, byte_mode, flag_upd, ctl_we;
  logic [3:0]  op;
  logic [15:0] opa, opb, result, flags;
  logic [2:0]  ctl_din;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_flags;
  bit done = 0;

  flag_alu uut (
    .clk(clk), .rst_n(rst_n), .op(op), .byte_mode(byte_mode),
    .opa(opa), .opb(opb), .flag_upd(flag_upd), .ctl_we(ctl_we),
    .ctl_din(ctl_din), .result(result), .flags(flags)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference: returns {known, of, sf, zf, af, pf, cf, result}
  function automatic logic [22:0] model(input int o, input int a, input int b, input bit bm);
    int w = bm ? 8 : 16;
    int m = bm ? 'hFF : 'hFFFF;
    int hb = 1 << (w - 1);
    int aa = a & m, bb = b & m, r = aa, full;
    bit cf = 0, of = 0, af = 0, kn = 1, sa, sb, sr, pf, zf, sf;
    sa = (aa & hb) != 0; sb = (bb & hb) != 0;
    case (o)
      0: begin full = aa + bb; r = full & m; cf = full > m; af = ((aa & 15) + (bb & 15)) > 15; end
      1: begin r = (aa - bb) & m; cf = aa < bb; af = (aa & 15) < (bb & 15); end
      2: r = aa & bb;
      3: r = aa | bb;
      4: r = aa ^ bb;
      5: begin r = (aa << 1) & m; cf = sa; end
      6: begin r = aa >> 1; cf = aa & 1; end
      7: begin r = (aa >> 1) | (aa & hb); cf = aa & 1; end
      8: begin r = ((aa << 1) | (sa ? 1 : 0)) & m; cf = sa; end
      9: begin r = (aa >> 1) | ((aa & 1) ? hb : 0); cf = aa & 1; end
      default: kn = 0;
    endcase
    sr = (r & hb) != 0;
    if (o == 0) of = (sa == sb) && (sr != sa);
    else if (o == 1) of = (sa != sb) && (sr != sa);
    else if (o >= 5 && o <= 9) of = sr ^ sa;
    pf = ($countones(r & 'hFF) % 2) == 0;
    zf = (r == 0);
    sf = sr;
    return {kn, of, sf, zf, af, pf, cf, r[15:0]};
  endfunction

  function automatic string rtag(input int o, input bit bm);
    if (bm) return "R9";
    if (o <= 1) return "R2";
    if (o <= 4) return "R7";
    if (o <= 9) return "R8";
    return "R13";
  endfunction

  task automatic apply(input int o, input int a, input int b, input bit bm,
                       input bit upd, input bit cw, input logic [2:0] cd);
    logic [22:0] m;
    @(negedge clk);
    op = 4'(o); opa = 16'(a); opb = 16'(b); byte_mode = bm;
    flag_upd = upd; ctl_we = cw; ctl_din = cd;
    m = model(o, a, b, bm);
    #1;
    chk(rtag(o, bm), result, m[15:0]);
    @(posedge clk);
    #1;
    if (upd && m[22]) begin
      exp_flags[0]  = m[16];
      exp_flags[2]  = m[17];
      exp_flags[4]  = m[18];
      exp_flags[6]  = m[19];
      exp_flags[7]  = m[20];
      exp_flags[11] = m[21];
    end
    if (cw) exp_flags[10:8] = cd;
    chk((o <= 1) ? "R2 carry" : (o <= 4) ? "R7 carry" : (o <= 9) ? "R8 carry" : "R13 carry",
        16'(flags[0]), 16'(exp_flags[0]));
    chk("R6 parity", 16'(flags[2]), 16'(exp_flags[2]));
    chk("R4 aux", 16'(flags[4]), 16'(exp_flags[4]));
    chk("R5 zero/sign", 16'(flags[7:6]), 16'(exp_flags[7:6]));
    chk("R3 overflow", 16'(flags[11]), 16'(exp_flags[11]));
    chk("R12 control", 16'(flags[10:8]), 16'(exp_flags[10:8]));
    chk(upd ? "R10 layout" : "R11 hold", flags, exp_flags);
  endtask

  initial begin
    #1500000;
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c3e));
    rst_n = 1'b0; op = '0; opa = '0; opb = '0; byte_mode = 1'b0;
    flag_upd = 1'b0; ctl_we = 1'b0; ctl_din = '0;
    exp_flags = 16'h0000;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset", flags, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sync release", flags, 16'h0000);
    repeat (2) @(negedge clk);

    // R2/R3/R4/R5 word and byte corners
    apply(0, 'h7FFF, 'h0001, 0, 1, 0, 3'b000);
    apply(0, 'hFFFF, 'h0001, 0, 1, 0, 3'b000);
    apply(0, 'h007F, 'h0001, 1, 1, 0, 3'b000);
    apply(0, 'h12FF, 'h3401, 1, 1, 0, 3'b000);
    apply(1, 'h0000, 'h0001, 0, 1, 0, 3'b000);
    apply(1, 'h8000, 'h0001, 0, 1, 0, 3'b000);
    apply(1, 'hAB80, 'h0001, 1, 1, 0, 3'b000);
    apply(1, 'h1234, 'h1234, 0, 1, 0, 3'b000);
    // R7 logic clears carry/overflow
    apply(2, 'hF0F0, 'h0FF0, 0, 1, 0, 3'b000);
    apply(4, 'hFFFF, 'hFFFF, 0, 1, 0, 3'b000);
    // R8 shifts and rotates, both widths
    apply(5, 'h8001, 0, 0, 1, 0, 3'b000);
    apply(6, 'h0003, 0, 0, 1, 0, 3'b000);
    apply(7, 'h8002, 0, 0, 1, 0, 3'b000);
    apply(7, 'h7F81, 0, 1, 1, 0, 3'b000);
    apply(8, 'h4080, 0, 1, 1, 0, 3'b000);
    apply(9, 'h0001, 0, 0, 1, 0, 3'b000);
    // R12 control writes, arithmetic after must not disturb them
    apply(0, 'h0001, 'h0001, 0, 0, 1, 3'b101);
    apply(0, 'hFFFF, 'hFFFF, 0, 1, 0, 3'b000);
    apply(3, 'h0000, 'h0000, 0, 1, 1, 3'b010);
    // R11 no strobe, R13 reserved
    apply(0, 'hFFFF, 'h0001, 0, 0, 0, 3'b000);
    apply(12, 'hBEEF, 'h1111, 0, 1, 0, 3'b000);
    apply(15, 'hBEEF, 'h1111, 1, 1, 0, 3'b000);

    for (int i = 0; i < 600; i++) begin
      apply($urandom_range(0, 11), $urandom_range(0, 'hFFFF), $urandom_range(0, 'hFFFF),
            $urandom_range(0, 1), ($urandom_range(0, 3) != 0), ($urandom_range(0, 7) == 0),
            3'($urandom_range(0, 7)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule